// File: doc/BRIEF.md
# Multi-Format Serial PCM Audio Receiver

This block takes stereo PCM audio off a three-wire serial link: a bit clock, a frame clock that tells the left half-frame from the right one, and one data line. It turns each left/right word pair into two parallel 24-bit sign-extended samples and marks them with a one-cycle valid strobe. The whole block runs on the bit clock, so the data line and the frame clock are both sampled on its rising edge.

Three runtime inputs set the link format. A 3-bit code picks the justification and the word length. Right-justified words sit at the end of a half-frame. Left-justified words start at the frame clock transition. I2S words start one bit clock after it. A separate polarity input picks which frame clock level marks the left channel. Frame timing is checked. A half-frame that started before reset was released, a left/justified or I2S half-frame too short to hold its word, and a right word with no left word from the same frame all produce no output.

Top module: `pcm_serial_rx`

## Requirements
- R1: After synchronous reset, `pair_valid` is 0 and `left_o` and `right_o` are both 0.
- R2: Format codes 000, 001 and 010 select right-justified words of 16, 20 and 24 bits. The word is the last N bits shifted in, MSB first, before the frame clock transition that ends the half-frame. Earlier bits are ignored.
- R3: Format codes 111 and 011 select left-justified words of 20 and 24 bits. The word is the first N bits shifted in, MSB first, starting with the bit sampled on the edge where the new frame clock level is first seen. Later bits are ignored.
- R4: Format codes 100, 110 and 101 select I2S words of 16, 20 and 24 bits. They are left-justified, but the MSB comes one bit clock after the edge where the new frame clock level is first seen.
- R5: Each output word is sign-extended from its word length to 24 bits, so bits 23 down to N-1 all equal the word's MSB.
- R6: With `lr_swap` = 0, a high frame clock marks the left half-frame. With `lr_swap` = 1, a low frame clock marks it. The left word of a frame always comes before its right word.
- R7: `pair_valid` pulses for exactly one cycle. For right-justified formats it rises right after the first edge that samples the frame clock at the left level after the right half. For the other formats it rises right after the edge that samples the right word's LSB. `left_o` and `right_o` change only with that pulse.
- R8: In right-justified formats, if a half-frame carries fewer than N bits, the missing upper bits are zero before sign extension.
- R9: In left-justified and I2S formats, a half-frame that ends before its word is complete produces no output for that frame. The next well-formed frame is output normally.
- R10: A half-frame already in progress when reset is released never contributes a word. A right word with no left word earlier in the same frame produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frm_clk | input | 1 | Frame clock; its level marks the left or right half-frame |
| ser_din | input | 1 | Serial audio data, MSB first |
| fmt_sel | input | 3 | Format code (see R2 to R4) |
| lr_swap | input | 1 | Frame clock polarity (see R6) |
| left_o | output | 24 | Sign-extended left sample |
| right_o | output | 24 | Sign-extended right sample |
| pair_valid | output | 1 | One-cycle strobe; the left/right pair is new |

## Verification
A right-justified pair is due one register stage after the rising edge that first sees the frame clock back at the left level, so the pulse lands at bit index 0 of the following left half-frame. A left-justified pair is due at right-half bit index N-1, and an I2S pair at index N. The bench drives each bit on the falling edge and samples 1 ns after every rising edge. It requires the pulse at exactly the computed index of exactly one half-frame, carrying the arithmetically computed pair, and requires no pulse at any other bit of any half-frame. Short half-frames, partial leading half-frames and both polarities get the same per-bit watch.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  localparam int MAX_W = 24;
  localparam int NUM_W = 3;

  typedef enum logic [1:0] {
    JUST_RIGHT = 2'd0,
    JUST_LEFT  = 2'd1,
    JUST_I2S   = 2'd2
  } just_e;

  typedef struct packed {
    just_e      just;
    logic [1:0] wsel;   // 0:16 1:20 2:24 bits
  } fmt_t;

  function automatic fmt_t decode_fmt(input logic [2:0] code);
    fmt_t f;
    case (code)
      3'b000:  begin f.just = JUST_RIGHT; f.wsel = 2'd0; end
      3'b001:  begin f.just = JUST_RIGHT; f.wsel = 2'd1; end
      3'b010:  begin f.just = JUST_RIGHT; f.wsel = 2'd2; end
      3'b011:  begin f.just = JUST_LEFT;  f.wsel = 2'd2; end
      3'b100:  begin f.just = JUST_I2S;   f.wsel = 2'd0; end
      3'b101:  begin f.just = JUST_I2S;   f.wsel = 2'd2; end
      3'b110:  begin f.just = JUST_I2S;   f.wsel = 2'd1; end
      default: begin f.just = JUST_LEFT;  f.wsel = 2'd1; end
    endcase
    return f;
  endfunction

endpackage

// File: rtl/pcm_rx_frontend.sv
module pcm_rx_frontend #(
  parameter int SR_W  = 24,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_clk,
  input  logic             ser_din,
  output logic             hf_edge,
  output logic             cur_lvl,
  output logic             prev_lvl,
  output logic             started_q,
  output logic             started_d,
  output logic [SR_W-1:0]  sr_q,
  output logic [SR_W-1:0]  sr_d,
  output logic [CNT_W-1:0] cnt_d
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             armed_q;
  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;

  // a transition is only trusted once the previous level has been captured
  assign hf_edge   = armed_q && (frm_clk != lvl_q);
  assign cur_lvl   = frm_clk;
  assign prev_lvl  = lvl_q;
  assign started_d = started_q | hf_edge;

  always_comb begin
    if (hf_edge) begin
      sr_d  = {{(SR_W-1){1'b0}}, ser_din};
      cnt_d = CNT_ONE;
    end else begin
      sr_d  = {sr_q[SR_W-2:0], ser_din};
      cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      lvl_q     <= 1'b0;
      started_q <= 1'b0;
      sr_q      <= '0;
      cnt_q     <= '0;
    end else begin
      armed_q   <= 1'b1;
      lvl_q     <= frm_clk;
      started_q <= started_d;
      sr_q      <= sr_d;
      cnt_q     <= cnt_d;
    end
  end

endmodule

// File: rtl/pcm_rx_extract.sv
module pcm_rx_extract
  import pcm_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  fmt_t             cfg,
  input  logic             lr_swap,
  input  logic             hf_edge,
  input  logic             cur_lvl,
  input  logic             prev_lvl,
  input  logic             started_q,
  input  logic             started_d,
  input  logic [MAX_W-1:0] sr_q,
  input  logic [MAX_W-1:0] sr_d,
  input  logic [CNT_W-1:0] cnt_d,
  output logic             word_done,
  output logic             word_left,
  output logic [MAX_W-1:0] word_val
);

  logic             is_rj;
  logic             is_i2s;
  logic [CNT_W-1:0] target;
  logic [MAX_W-1:0] raw;
  logic [MAX_W-1:0] ext [NUM_W];

  assign is_rj  = (cfg.just == JUST_RIGHT);
  assign is_i2s = (cfg.just == JUST_I2S);
  assign target = CNT_W'(16) + CNT_W'({cfg.wsel, 2'b00}) + CNT_W'(is_i2s);

  always_comb begin
    if (is_rj) begin
      // the half-frame that just ended holds the word in its last bits
      word_done = hf_edge && started_q;
      word_left = prev_lvl ^ lr_swap;
      raw       = sr_q;
    end else begin
      word_done = started_d && (cnt_d == target);
      word_left = cur_lvl ^ lr_swap;
      raw       = sr_d;
    end
  end

  for (genvar k = 0; k < NUM_W; k++) begin : g_ext
    localparam int W = 16 + 4 * k;
    if (W >= MAX_W) begin : g_full
      assign ext[k] = raw;
    end else begin : g_sign
      assign ext[k] = {{(MAX_W-W){raw[W-1]}}, raw[W-1:0]};
    end
  end

  always_comb begin
    case (cfg.wsel)
      2'd0:    word_val = ext[0];
      2'd1:    word_val = ext[1];
      default: word_val = ext[2];
    endcase
  end

endmodule

// File: rtl/pcm_rx_pair.sv
module pcm_rx_pair #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_done,
  input  logic          word_left,
  input  logic [DW-1:0] word_val,
  input  logic          left_start,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          pair_valid
);

  logic          have_q;
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q     <= 1'b0;
      hold_q     <= '0;
      left_o     <= '0;
      right_o    <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (word_done && !word_left && have_q) begin
        left_o     <= hold_q;
        right_o    <= word_val;
        pair_valid <= 1'b1;
      end
      if (word_done && word_left) begin
        hold_q <= word_val;
        have_q <= 1'b1;
      end else if (left_start || (word_done && !word_left)) begin
        have_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             bclk,
  input  logic             rst,
  input  logic             frm_clk,
  input  logic             ser_din,
  input  logic [2:0]       fmt_sel,
  input  logic             lr_swap,
  output logic [MAX_W-1:0] left_o,
  output logic [MAX_W-1:0] right_o,
  output logic             pair_valid
);

  fmt_t             cfg;
  logic             hf_edge, cur_lvl, prev_lvl, started_q, started_d;
  logic [MAX_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0] cnt_d;
  logic             word_done, word_left;
  logic [MAX_W-1:0] word_val;
  logic             left_start;

  assign cfg        = decode_fmt(fmt_sel);
  assign left_start = hf_edge && (cur_lvl ^ lr_swap);

  pcm_rx_frontend #(.SR_W(MAX_W), .CNT_W(CNT_W)) u_front (
    .clk(bclk), .rst(rst), .frm_clk(frm_clk), .ser_din(ser_din),
    .hf_edge(hf_edge), .cur_lvl(cur_lvl), .prev_lvl(prev_lvl),
    .started_q(started_q), .started_d(started_d),
    .sr_q(sr_q), .sr_d(sr_d), .cnt_d(cnt_d)
  );

  pcm_rx_extract #(.CNT_W(CNT_W)) u_extract (
    .cfg(cfg), .lr_swap(lr_swap), .hf_edge(hf_edge), .cur_lvl(cur_lvl),
    .prev_lvl(prev_lvl), .started_q(started_q), .started_d(started_d),
    .sr_q(sr_q), .sr_d(sr_d), .cnt_d(cnt_d),
    .word_done(word_done), .word_left(word_left), .word_val(word_val)
  );

  pcm_rx_pair #(.DW(MAX_W)) u_pair (
    .clk(bclk), .rst(rst), .word_done(word_done), .word_left(word_left),
    .word_val(word_val), .left_start(left_start),
    .left_o(left_o), .right_o(right_o), .pair_valid(pair_valid)
  );

endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk
  import pcm_rx_pkg::*;
(
  input logic             bclk,
  input logic             rst,
  input logic             frm_clk,
  input logic [2:0]       fmt_sel,
  input logic             lr_swap,
  input logic [MAX_W-1:0] left_o,
  input logic [MAX_W-1:0] right_o,
  input logic             pair_valid
);

  fmt_t cfg;
  assign cfg = decode_fmt(fmt_sel);

  // R1
  reset_clear_chk: assert property (@(posedge bclk) disable iff (rst)
    $fell(rst) |-> (!pair_valid && left_o == '0 && right_o == '0));

  // R7
  single_pulse_chk: assert property (@(posedge bclk) disable iff (rst)
    pair_valid |=> !pair_valid);

  // R7
  hold_outputs_chk: assert property (@(posedge bclk) disable iff (rst)
    !pair_valid |-> ($stable(left_o) && $stable(right_o)));

  // R5
  sign_ext16_chk: assert property (@(posedge bclk) disable iff (rst)
    (pair_valid && cfg.wsel == 2'd0) |->
      ((left_o[23:15] == '0 || left_o[23:15] == '1) &&
       (right_o[23:15] == '0 || right_o[23:15] == '1)));

  // R6
  rj_left_level_chk: assert property (@(posedge bclk) disable iff (rst)
    (pair_valid && cfg.just == JUST_RIGHT) |-> $past(frm_clk ^ lr_swap));

  // R6
  lj_right_level_chk: assert property (@(posedge bclk) disable iff (rst)
    (pair_valid && cfg.just != JUST_RIGHT) |-> !$past(frm_clk ^ lr_swap));

endmodule

bind pcm_serial_rx pcm_serial_rx_chk u_chk (
  .bclk(bclk), .rst(rst), .frm_clk(frm_clk), .fmt_sel(fmt_sel),
  .lr_swap(lr_swap), .left_o(left_o), .right_o(right_o),
  .pair_valid(pair_valid)
);

// File: tb/tb_pcm_serial_rx.sv
module tb_pcm_serial_rx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm = 1'b0;
  logic        din = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic        pol = 1'b0;
  logic [23:0] left_o, right_o;
  logic        pair_valid;

  always #2 clk = ~clk;

  pcm_serial_rx dut (
    .bclk(clk), .rst(rst), .frm_clk(frm), .ser_din(din), .fmt_sel(fmt),
    .lr_swap(pol), .left_o(left_o), .right_o(right_o), .pair_valid(pair_valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done_f = 0;
  bit pend = 0;
  logic [23:0] pL, pR;

  // word length and mode per R2..R4 (0 right-just, 1 left-just, 2 I2S)
  function automatic int wlen(input logic [2:0] f);
    case (f)
      3'd0, 3'd4:       return 16;
      3'd1, 3'd6, 3'd7: return 20;
      default:          return 24;
    endcase
  endfunction

  function automatic int fmode(input logic [2:0] f);
    if (f <= 3'd2) return 0;
    if (f == 3'd3 || f == 3'd7) return 1;
    return 2;
  endfunction

  function automatic logic [23:0] lowmask(input int n);
    return (n >= 24) ? 24'hFFFFFF : ((24'h1 << n) - 24'h1);
  endfunction

  function automatic logic [23:0] sx(input logic [23:0] w, input int n);
    logic [23:0] r;
    r = w & lowmask(n);
    if (r[n-1]) r = r | ~lowmask(n);
    return r;
  endfunction

  function automatic logic [63:0] mk_half(input logic [2:0] f, input logic [23:0] w, input int h);
    logic [63:0] b;
    int n, m;
    n = wlen(f);
    m = fmode(f);
    b = '0;
    for (int i = 0; i < h; i++) begin
      if (m == 0)      b[i] = (i >= h - n) ? w[h-1-i] : 1'b1;
      else if (m == 1) b[i] = (i < n) ? w[n-1-i] : i[0];
      else             b[i] = (i == 0) ? 1'b1 : ((i <= n) ? w[n-i] : 1'b0);
    end
    return b;
  endfunction

  function automatic logic [23:0] pat(input int f, input int p, input int k, input int ch);
    if (k == 0) return 24'hFFFFFF;
    if (k == 1) return 24'h1 << (wlen(3'(f)) - 1);
    return 24'((f*37 + p*11 + k*5 + ch*3 + 1) * 24'h9E3779) ^ 24'h35A1C7;
  endfunction

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h (fmt=%0d pol=%0d)", req, act, exp, fmt, pol);
    end
  endtask

  // drive one half-frame; expect a pulse only at bit exp_idx (or none if -1)
  task automatic run_half(input bit lvl, input logic [63:0] bits, input int h, input int exp_idx,
                          input logic [23:0] eL, input logic [23:0] eR, input string req);
    int extra;
    bit got;
    logic [23:0] gL, gR;
    extra = 0; got = 0; gL = '0; gR = '0;
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      frm = lvl;
      din = bits[i];
      @(posedge clk);
      #1;
      if (pair_valid) begin
        if (i == exp_idx) begin got = 1; gL = left_o; gR = right_o; end
        else extra++;
      end
    end
    if (exp_idx >= 0) check(got && extra == 0, req, {gL, gR}, {eL, eR});
    else              check(extra == 0, req, 48'(extra), 48'd0);
  endtask

  task automatic send_frame(input logic [23:0] wl, input logic [23:0] wr, input int hl,
                            input int hr, input string req, input bit expect_out);
    int n, m, idx;
    n = wlen(fmt);
    m = fmode(fmt);
    idx = (m == 0 && pend) ? 0 : -1;
    run_half(~pol, mk_half(fmt, wl, hl), hl, idx, pL, pR, req);
    pend = 0;
    if (m == 0) begin
      run_half(pol, mk_half(fmt, wr, hr), hr, -1, '0, '0, req);
      pend = expect_out;
      pL = sx(wl & lowmask(hl), n);
      pR = sx(wr & lowmask(hr), n);
    end else begin
      idx = expect_out ? (n - 1 + (m == 2 ? 1 : 0)) : -1;
      run_half(pol, mk_half(fmt, wr, hr), hr, idx, sx(wl, n), sx(wr, n), req);
    end
  endtask

  task automatic flush(input string req);
    run_half(~pol, 64'h0, 4, pend ? 0 : -1, pL, pR, req);
    pend = 0;
  endtask

  task automatic do_reset(input bit lvl);
    rst = 1; frm = lvl; din = 0; pend = 0;
    repeat (3) @(negedge clk);
    #1;
    check(!pair_valid && left_o == '0 && right_o == '0, "R1 reset state",
          {left_o, right_o} | 48'(pair_valid), 48'd0);
    @(negedge clk);
    rst = 0;
  endtask

  function automatic string req_of(input logic [2:0] f, input bit p);
    string s;
    case (fmode(f))
      0:       s = "R2";
      1:       s = "R3";
      default: s = "R4";
    endcase
    if (wlen(f) < 24) s = {s, " R5"};
    if (p) s = {s, " R6"};
    return {s, " R7"};
  endfunction

  initial begin
    #(4 * 150000);
    if (!done_f) begin
      n_bad++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // full sweep: every format code, both polarities, several words and half-frame lengths
    for (int f = 0; f < 8; f++) begin
      for (int p = 0; p < 2; p++) begin
        fmt = 3'(f);
        pol = p[0];
        do_reset(pol);
        run_half(pol, 64'h1F, 5, -1, '0, '0, "R10 lead-in");
        for (int k = 0; k < 4; k++)
          send_frame(pat(f, p, k, 0), pat(f, p, k, 1), 26 + 3*k, 26 + 3*k, req_of(3'(f), pol), 1);
        flush(req_of(3'(f), pol));
      end
    end

    // R8: short right-justified half-frames, upper bits zero
    fmt = 3'd2; pol = 0;
    do_reset(pol);
    run_half(pol, 64'h3, 3, -1, '0, '0, "R8 lead-in");
    send_frame(24'hABCDEF, 24'hF12345, 10, 32, "R8 short left", 1);
    send_frame(24'h123456, 24'h8ACE13, 32, 7, "R8 short right", 1);
    flush("R8");
    fmt = 3'd0; pol = 1;
    do_reset(pol);
    run_half(pol, 64'h1, 2, -1, '0, '0, "R8 lead-in");
    send_frame(24'h00FFFF, 24'h008000, 8, 16, "R8 short 16", 1);
    flush("R8");

    // R9: left-justified / I2S half-frames too short
    fmt = 3'd3; pol = 0;
    do_reset(pol);
    run_half(pol, 64'h1, 2, -1, '0, '0, "R9 lead-in");
    send_frame(24'h765432, 24'h89ABCD, 12, 32, "R9 short left", 0);
    send_frame(24'h111111, 24'hEEEEEE, 32, 30, "R9 recovery", 1);
    send_frame(24'h222222, 24'h333333, 32, 10, "R9 short right", 0);
    send_frame(24'h444444, 24'h555555, 24, 24, "R9 exact length", 1);
    fmt = 3'd4; pol = 1;
    do_reset(pol);
    run_half(pol, 64'h1, 2, -1, '0, '0, "R9 lead-in");
    send_frame(24'h00BEEF, 24'h001234, 16, 20, "R9 i2s one short", 0);
    send_frame(24'h00BEEF, 24'h001234, 17, 17, "R9 i2s exact", 1);

    // R10: partial leading left half-frame never pairs
    for (int f = 2; f < 4; f++) begin
      fmt = 3'(f); pol = 0;
      do_reset(~pol);
      run_half(~pol, 64'hFFFFFFFF, 30, -1, '0, '0, "R10 partial left");
      run_half(pol, mk_half(fmt, 24'h5A5A5A, 30), 30, -1, '0, '0, "R10 lone right");
      send_frame(24'h0F0F0F, 24'hF0F0F0, 28, 28, "R10 first full frame", 1);
      flush("R10");
    end

    done_f = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule